// File: doc/BRIEF.md
# Grouped-Request Word FIFO Bridge

This block carries 16-bit words from a producer on one bus to a DMA channel on another bus. The producer writes words one at a time into an eight-entry FIFO. The DMA side does not see a request for each word. It sees a request only once the producer has built up a whole group of four words, so its bursts stay aligned to groups. The DMA side then acknowledges words one by one. Each word is presented together with a destination address that moves up by two bytes for every word taken.

A configuration strobe sets the transfer. It loads the number of words the DMA side will take and the first destination address. The same strobe raises the transfer-active flag when the count is nonzero and clears the sticky overflow flag. Each accepted acknowledge counts the remaining length down by one. When the count reaches zero, the active flag drops and the request is withdrawn. Words written while the FIFO is full are discarded, and the overflow flag records that a word was lost. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after the input goes high.

Top module: `word_dreq_bridge`

## Requirements
- R1: A write with `wr_en` high while fewer than 8 words are held is stored. Words leave on `rd_data` in the order they were written, and `rd_data` always shows the oldest word held.
- R2: A write while 8 words are held is discarded and leaves the FIFO contents unchanged, even if a word is popped in the same cycle. It sets `overflow`, which stays set until a `cfg_we` strobe clears it. A discard in the same cycle as the strobe leaves `overflow` set.
- R3: `full` is high in exactly the cycles in which the FIFO holds 8 words.
- R4: `dreq` rises in the cycle after an accepted write leaves the FIFO holding 4 or 8 words while the remaining length is nonzero. It never rises after a write that leaves any other count.
- R5: Once raised, `dreq` stays high while words drain. It falls in the cycle after the FIFO becomes empty or the remaining length becomes zero.
- R6: An acknowledge (`dack` high) pops one word only when the FIFO is not empty and `active` is high. Otherwise it changes neither the contents, the length nor the address.
- R7: Each accepted acknowledge lowers `xfer_len` by one. A `cfg_we` strobe in the same cycle overrides this and loads `cfg_len`.
- R8: `cfg_we` sets `active` when `cfg_len` is nonzero and clears it when `cfg_len` is zero. `active` clears in the cycle after the pop that brings `xfer_len` to zero.
- R9: `rd_addr` takes `cfg_addr` on a `cfg_we` strobe and moves up by 2 with each accepted acknowledge.
- R10: During and right after reset the block holds 0 words. `full`, `dreq`, `active` and `overflow` are low, and `xfer_len` and `rd_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 16 | Producer write word |
| cfg_we | input | 1 | Loads length and start address, clears overflow |
| cfg_len | input | 16 | Number of words to transfer |
| cfg_addr | input | 32 | First destination byte address |
| dack | input | 1 | DMA acknowledge, pops one word |
| full | output | 1 | FIFO holds 8 words |
| overflow | output | 1 | Sticky flag: a write was discarded |
| active | output | 1 | Transfer in progress (length nonzero) |
| xfer_len | output | 16 | Remaining word count |
| dreq | output | 1 | DMA request |
| rd_data | output | 16 | Oldest word held |
| rd_addr | output | 32 | Destination address for `rd_data` |

## Verification
The bench runs several input patterns and compares every output against a queue-based model on each clock.

- **Single writes up to four words:** these separate a request raised per group from one raised per word.
- **Filling to eight and then writing more:** this exposes the full boundary and the discard path.
- **Acknowledges that arrive together with writes at the full boundary:** these test that a simultaneous pop does not rescue a discarded write.
- **Draining past the end of the configured length and past an empty FIFO:** these show that an acknowledge is ignored once there is nothing left to take.
- **A long pseudo-random mix of writes, acknowledges and occasional reconfiguration:** this covers orderings that the directed cases miss, including a reconfiguration with a zero length.

// File: rtl/wdb_pkg.sv
package wdb_pkg;

  // Per-cycle outcome of the FIFO handshake, shared by the control blocks.
  typedef struct packed {
    logic push_ok;  // write accepted this cycle
    logic pop_ok;   // acknowledge accepted this cycle
    logic drop;     // write discarded because the FIFO was full
  } wdb_evt_t;

endpackage

// File: rtl/wdb_fifo.sv
module wdb_fifo #(
  parameter int DEPTH = 8,   // power of two
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop_req,
  output logic [WIDTH-1:0]           head_data,
  output logic [$clog2(DEPTH):0]     count,
  output logic [$clog2(DEPTH):0]     count_nxt,
  output logic                       full,
  output logic                       empty,
  output wdb_pkg::wdb_evt_t          evt
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // Pointers carry one extra bit so that full and empty differ.
  logic [CNT_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [DEPTH-1:0][WIDTH-1:0] mem_q;
  logic [DEPTH-1:0] we_vec;
  logic push_ok, pop_ok;

  assign count = wr_ptr_q - rd_ptr_q;
  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  // A write is accepted only if a slot is free before this edge.
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  assign evt.push_ok = push_ok;
  assign evt.pop_ok  = pop_ok;
  assign evt.drop    = push_req && full;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + CNT_W'(1);
    if (pop_ok)  rd_ptr_d = rd_ptr_q + CNT_W'(1);
  end

  assign count_nxt = wr_ptr_d - rd_ptr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // One write enable for each storage slot.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_we
    assign we_vec[gi] = push_ok && (wr_ptr_q[PTR_W-1:0] == PTR_W'(gi));
  end

  // Data storage has no reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_vec[i]) mem_q[i] <= push_data;
    end
  end

  assign head_data = mem_q[rd_ptr_q[PTR_W-1:0]];

  // R2: a discarded write never adds a word.
  p_drop_keeps_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> full);

  // R3: occupancy never exceeds capacity.
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R6: a pop on an empty FIFO does nothing.
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> empty);

  // R1: one accepted write alone adds exactly one word.
  p_push_adds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_req) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/wdb_xfer.sv
module wdb_xfer #(
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              pop_ok,
  input  logic              drop,
  output logic [LEN_W-1:0]  len,
  output logic              len_nxt_zero,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic              overflow
);
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              act_q, act_d;
  logic              ovf_q, ovf_d;

  always_comb begin
    len_d  = len_q;
    addr_d = addr_q;
    act_d  = act_q;
    if (cfg_we) begin
      len_d  = cfg_len;
      addr_d = cfg_addr;
      act_d  = (cfg_len != '0);
    end else if (pop_ok) begin
      len_d  = len_q - LEN_W'(1);
      addr_d = addr_q + ADDR_W'(ADDR_STEP);
      act_d  = (len_q != LEN_W'(1));
    end
    // A discard in the same cycle as a reconfiguration is still recorded.
    ovf_d = (cfg_we ? 1'b0 : ovf_q) | drop;
  end

  assign len_nxt_zero = (len_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      addr_q <= '0;
      act_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      len_q  <= len_d;
      addr_q <= addr_d;
      act_q  <= act_d;
      ovf_q  <= ovf_d;
    end
  end

  assign len      = len_q;
  assign addr     = addr_q;
  assign active   = act_q;
  assign overflow = ovf_q;

  // R7: each accepted pop lowers the length by one.
  p_len_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !cfg_we) |=> (len == $past(len) - LEN_W'(1)));

  // R8: the active flag agrees with a nonzero remaining length.
  p_active_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active == (len != '0));

  // R9: each accepted pop moves the address up by one step.
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !cfg_we) |=> (addr == $past(addr) + ADDR_W'(ADDR_STEP)));

  // R2: overflow stays set until a reconfiguration.
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cfg_we) |=> overflow);
endmodule

// File: rtl/wdb_dreq.sv
module wdb_dreq #(
  parameter int CNT_W = 4,
  parameter int GROUP = 4   // power of two
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             len_nxt_zero,
  output logic             dreq
);
  localparam int GRP_BITS = $clog2(GROUP);

  logic dreq_q, dreq_d;
  logic at_group;

  // The next occupancy lands exactly on a whole group.
  assign at_group = (count_nxt != '0) && (count_nxt[GRP_BITS-1:0] == '0);

  always_comb begin
    dreq_d = dreq_q;
    if (push_ok && at_group) dreq_d = 1'b1;
    if ((count_nxt == '0) || len_nxt_zero) dreq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_q <= 1'b0;
    else        dreq_q <= dreq_d;
  end

  assign dreq = dreq_q;

  // R4: a new request only appears on a whole group of words.
  p_rise_on_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> ((count != '0) && (count[GRP_BITS-1:0] == '0)));

  // R5: there is never a request with nothing to take.
  p_no_req_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !dreq);
endmodule

// File: rtl/word_dreq_bridge.sv
module word_dreq_bridge #(
  parameter int DEPTH     = 8,
  parameter int WIDTH     = 16,
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int GROUP     = 4,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              cfg_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              dack,
  output logic              full,
  output logic              overflow,
  output logic              active,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              dreq,
  output logic [WIDTH-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  // Asserted asynchronously, released on the second clock edge.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic rst_sync_n;
  assign rst_sync_n = rst_s2_q;

  wdb_pkg::wdb_evt_t evt;
  logic [CNT_W-1:0]  count, count_nxt;
  logic              empty, len_nxt_zero;
  logic              pop_req;

  // An acknowledge counts only while a transfer is active.
  assign pop_req = dack && active;

  wdb_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_req  (wr_en),
    .push_data (wr_data),
    .pop_req   (pop_req),
    .head_data (rd_data),
    .count     (count),
    .count_nxt (count_nxt),
    .full      (full),
    .empty     (empty),
    .evt       (evt)
  );

  wdb_xfer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_we       (cfg_we),
    .cfg_len      (cfg_len),
    .cfg_addr     (cfg_addr),
    .pop_ok       (evt.pop_ok),
    .drop         (evt.drop),
    .len          (xfer_len),
    .len_nxt_zero (len_nxt_zero),
    .active       (active),
    .addr         (rd_addr),
    .overflow     (overflow)
  );

  wdb_dreq #(.CNT_W(CNT_W), .GROUP(GROUP)) u_dreq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .push_ok      (evt.push_ok),
    .count        (count),
    .count_nxt    (count_nxt),
    .len_nxt_zero (len_nxt_zero),
    .dreq         (dreq)
  );

  // R6: an acknowledge on an empty FIFO is not taken.
  p_pop_needs_word_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dack && empty) |-> !evt.pop_ok);

  // R5: the request stays up while words remain and the length is nonzero.
  p_req_holds_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dreq && !cfg_we && !len_nxt_zero && (count_nxt != '0)) |=> dreq);
endmodule

// File: tb/word_dreq_bridge_tb.sv
`timescale 1ns/1ps
module word_dreq_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, cfg_we, dack;
  logic [15:0] wr_data, cfg_len;
  logic [31:0] cfg_addr;
  logic        full, overflow, active, dreq;
  logic [15:0] xfer_len, rd_data;
  logic [31:0] rd_addr;

  always #4 clk = ~clk;   // 125 MHz

  word_dreq_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_addr(cfg_addr), .dack(dack),
    .full(full), .overflow(overflow), .active(active), .xfer_len(xfer_len),
    .dreq(dreq), .rd_data(rd_data), .rd_addr(rd_addr)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // Behavioural reference state.
  logic [15:0] mq[$];
  int          m_len;
  logic [31:0] m_addr;
  bit          m_act, m_ovf, m_dreq;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 full", {31'd0, full}, {31'd0, mq.size() == 8});
    check("R4 R5 dreq", {31'd0, dreq}, {31'd0, m_dreq});
    check("R8 active", {31'd0, active}, {31'd0, m_act});
    check("R2 overflow", {31'd0, overflow}, {31'd0, m_ovf});
    check("R7 length", {16'd0, xfer_len}, m_len[31:0]);
    check("R9 address", rd_addr, m_addr);
    if (mq.size() > 0) check("R1 R6 head word", {16'd0, rd_data}, {16'd0, mq[0]});
  endtask

  // Drive one cycle, update the model at the edge, compare at the falling edge.
  task automatic step(input bit w, input logic [15:0] d, input bit ack,
                      input bit c, input logic [15:0] cl, input logic [31:0] ca);
    int  sz;
    bit  push_ok, pop_ok, drop;
    wr_en = w; wr_data = d; dack = ack; cfg_we = c; cfg_len = cl; cfg_addr = ca;
    @(posedge clk);
    sz      = mq.size();
    push_ok = w && (sz < 8);
    pop_ok  = ack && (sz > 0) && m_act;
    drop    = w && (sz >= 8);
    if (pop_ok)  void'(mq.pop_front());
    if (push_ok) mq.push_back(d);
    if (c) begin
      m_len = int'(cl); m_addr = ca; m_act = (cl != 0);
    end else if (pop_ok) begin
      m_len--; m_addr += 32'd2; m_act = (m_len != 0);
    end
    m_ovf = (c ? 1'b0 : m_ovf) | drop;
    if (push_ok && mq.size() != 0 && (mq.size() % 4) == 0) m_dreq = 1'b1;
    if (mq.size() == 0 || m_len == 0) m_dreq = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 32'h0);
  endtask

  task automatic put(input logic [15:0] d);
    step(1'b1, d, 1'b0, 1'b0, 16'h0, 32'h0);
  endtask

  task automatic take();
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 32'h0);
  endtask

  task automatic configure(input logic [15:0] l, input logic [31:0] a);
    step(1'b0, 16'h0, 1'b0, 1'b1, l, a);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; wr_en = 0; dack = 0; cfg_we = 0;
    wr_data = 0; cfg_len = 0; cfg_addr = 0;
    m_len = 0; m_addr = 0; m_act = 0; m_ovf = 0; m_dreq = 0;
    repeat (3) @(negedge clk);
    // R10: reset values while reset is held
    check("R10 full", {31'd0, full}, 32'd0);
    check("R10 dreq", {31'd0, dreq}, 32'd0);
    check("R10 active", {31'd0, active}, 32'd0);
    check("R10 overflow", {31'd0, overflow}, 32'd0);
    check("R10 length", {16'd0, xfer_len}, 32'd0);
    check("R10 address", rd_addr, 32'd0);
    rst_n = 1'b1;
    repeat (3) idle();

    // R4: three words give no request, the fourth raises it
    configure(16'd10, 32'h2000_0100);
    put(16'hA001); put(16'hA002); put(16'hA003);
    check("R4 no request below group", {31'd0, dreq}, 32'd0);
    put(16'hA004);
    check("R4 request at four", {31'd0, dreq}, 32'd1);
    // R5: the request holds while draining
    take(); take();
    check("R5 request held", {31'd0, dreq}, 32'd1);
    // R3 and R2: fill to eight, then overfill, including with a pop in the same cycle
    for (int i = 0; i < 6; i++) put(16'hB000 + 16'(i));
    check("R3 full at eight", {31'd0, full}, 32'd1);
    put(16'hDEAD);
    check("R2 overflow set", {31'd0, overflow}, 32'd1);
    step(1'b1, 16'hBEEF, 1'b1, 1'b0, 16'h0, 32'h0);
    // R6 R7 R8: drain until the length reaches zero, then acknowledges are ignored
    for (int i = 0; i < 8; i++) take();
    check("R8 active cleared", {31'd0, active}, 32'd0);
    take(); take();
    check("R6 ignored when inactive", {16'd0, xfer_len}, 32'd0);
    // R2: reconfiguration clears overflow; R9 address restarts
    configure(16'd20, 32'h0000_0400);
    check("R2 overflow cleared", {31'd0, overflow}, 32'd0);
    check("R9 start address", rd_addr, 32'h0000_0400);
    while (mq.size() > 0) take();
    take();   // R6: acknowledge on an empty FIFO is ignored
    // R8: a zero-length reconfiguration leaves the block inactive
    configure(16'd0, 32'h0000_0800);
    put(16'h1111); put(16'h2222); put(16'h3333); put(16'h4444);
    check("R4 no request with zero length", {31'd0, dreq}, 32'd0);
    configure(16'd600, 32'h1000_0000);

    // Mixed pattern: writes, acknowledges and occasional reconfiguration
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[7:0] == 8'h3C)
        step(lfsr[9], lfsr[31:16], lfsr[10], 1'b1, {8'd0, lfsr[15:8]}, {16'h3000, lfsr[31:16]});
      else
        step(lfsr[3] | lfsr[4], lfsr[31:16], lfsr[5] & lfsr[6], 1'b0, 16'h0, 32'h0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule